// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block holds a two-word interrupt command register and turns a software write of the low word into an inter-processor interrupt. The command names a vector, a delivery mode, a destination mode, level and trigger bits and a destination shorthand. The high word supplies an 8-bit destination. From these fields and the local processor index, the block works out which processors are targeted. The other processors receive a one-cycle message carrying a target bitmask. The local processor receives a one-cycle self-delivery strobe. Both carry the same message fields.

Each remote target returns one response strobe. A pending counter is loaded with the number of remote targets, and each response counts it down. While the counter is non-zero, a busy bit is set, and it reads back as the delivery-status bit of the low word. While busy is set, further low-word writes are dropped. The number of processors present is an input of up to `NUM_CPU`, and indices at or above it are never targeted.

Top module: `ipi_cmd_sender`

## Requirements
- R1: A low-word write while busy is 1 is discarded: no message or self strobe follows, and the low word keeps its previous contents.
- R2: An accepted low-word write updates the message outputs one clock edge after the write is sampled. The low word is laid out as vector [7:0], delivery mode [10:8], destination mode [11] (1 = logical), delivery status [12] (read-only, equal to busy), level [14], trigger [15] and shorthand [19:18]. The message fields come from the low word, and the destination comes from the stored high word.
- R3: Shorthand 0, physical mode, destination 0xFF: every processor other than the local one is set in the target mask, and the self strobe fires.
- R4: Shorthand 0, physical mode, any other destination: a destination equal to the local index gives only the self strobe. Otherwise the single bit of that index is set in the target mask.
- R5: Shorthand 0, logical mode: target bit i is destination bit i, local bit included, with no self strobe.
- R6: Shorthand 1 gives only the self strobe. Shorthand 2 gives the self strobe plus all other processors. Shorthand 3 gives all other processors and no self strobe.
- R7: An accepted command loads the pending counter with the number of targets in the mask and sets busy. Each response strobe decrements the counter, and busy clears on the edge where the counter reaches zero. Responses while idle have no effect.
- R8: An accepted command with an empty target mask leaves busy at 0 after its edge.
- R9: Delivery mode 1 (lowest priority) with shorthand 0 raises errPulse for one cycle and sends nothing. Busy and the low word are unchanged.
- R10: A high-word write keeps only bits [31:24]. All other bits of the high word read 0.
- R11: Processor indices at or above numProcs never appear in the target mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrLo | input | 1 | Write strobe for the low command word |
| wrHi | input | 1 | Write strobe for the high command word |
| wrData | input | 32 | Write data |
| localId | input | ID_W | Index of the local processor |
| numProcs | input | ID_W+1 | Number of processors present |
| respValid | input | 1 | One response returned from a remote target |
| loWord | output | 32 | Low word readback, status bit in [12] |
| hiWord | output | 32 | High word readback |
| msgValid | output | 1 | Outgoing message strobe |
| msgTargets | output | NUM_CPU | Remote target bitmask |
| msgVector | output | 8 | Message vector |
| msgDelMode | output | 3 | Message delivery mode |
| msgDestMode | output | 1 | Message destination mode |
| msgLevel | output | 1 | Message level bit |
| msgTrigger | output | 1 | Message trigger bit |
| msgDest | output | 8 | Message destination byte |
| selfValid | output | 1 | Self-delivery strobe |
| errPulse | output | 1 | Rejected lowest-priority command |
| busy | output | 1 | Deliveries outstanding |

## Verification
The target mask, the message fields, the self strobe, errPulse and the rise of busy all come from registers. They are due on the first clock edge after the edge that samples wrLo. The bench drives its inputs on falling edges and checks these results on the next falling edge. Busy falls on the edge that samples the last response strobe, so the bench checks busy before each response and once more on the falling edge after the last one. High-word readback is due one edge after wrHi and is checked at the next falling edge.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int DMODE_BIT = 11;
  localparam int STAT_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  localparam logic [2:0] MODE_LOWPRI = 3'd1;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic load;
    logic err;
  } ctlStrobe_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int CNT_W = $clog2(NUM_CPU + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrLo,
  input  logic               respValid,
  input  logic [2:0]         reqMode,
  input  logic [1:0]         reqShort,
  input  logic [NUM_CPU-1:0] remoteMask,
  output ctlStrobe_t         ctl,
  output logic               busy
);
  logic [CNT_W-1:0] pendCnt;
  logic [CNT_W-1:0] remoteCnt;
  logic             accept;
  logic             lowPri;

  assign accept    = wrLo && !busy;
  assign lowPri    = (reqMode == MODE_LOWPRI) && (reqShort == SH_NONE);
  assign ctl.load  = accept && !lowPri;
  assign ctl.err   = accept && lowPri;
  assign remoteCnt = CNT_W'($countones(remoteMask));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
      busy    <= 1'b0;
    end else if (ctl.load) begin
      pendCnt <= remoteCnt;
      busy    <= (remoteCnt != '0);
    end else if (respValid && (pendCnt != '0)) begin
      pendCnt <= pendCnt - 1'b1;
      busy    <= (pendCnt != CNT_W'(1));
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic               wrHi,
  input  logic [31:0]        wrData,
  input  logic [ID_W-1:0]    localId,
  input  logic [ID_W:0]      numProcs,
  input  logic               busy,
  output logic [NUM_CPU-1:0] remoteMask,
  output logic [31:0]        loWord,
  output logic [31:0]        hiWord,
  output logic               msgValid,
  output logic [NUM_CPU-1:0] msgTargets,
  output logic [7:0]         msgDest,
  output logic               selfValid,
  output logic               errPulse
);
  logic [31:0]        loReg;
  logic [7:0]         destReg;
  logic [NUM_CPU-1:0] allMask;
  logic [NUM_CPU-1:0] selfBit;
  logic [NUM_CPU-1:0] othersMask;
  logic               selfHit;
  logic [1:0]         sh;
  logic               logical;

  assign sh      = wrData[SH_LSB +: 2];
  assign logical = wrData[DMODE_BIT];

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      allMask[i] = ((ID_W+1)'(i) < numProcs);
      selfBit[i] = (ID_W'(i) == localId);
    end
  end

  assign othersMask = allMask & ~selfBit;

  always_comb begin
    remoteMask = '0;
    selfHit    = 1'b0;
    unique case (sh)
      SH_NONE: begin
        if (logical) begin
          remoteMask = destReg[NUM_CPU-1:0] & allMask;
        end else if (destReg == 8'hFF) begin
          remoteMask = othersMask;
          selfHit    = 1'b1;
        end else if (destReg == 8'(localId)) begin
          selfHit = 1'b1;
        end else begin
          for (int i = 0; i < NUM_CPU; i++)
            remoteMask[i] = (destReg == 8'(i)) && allMask[i];
        end
      end
      SH_SELF:   selfHit = 1'b1;
      SH_ALL: begin
        remoteMask = othersMask;
        selfHit    = 1'b1;
      end
      default:   remoteMask = othersMask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg      <= '0;
      destReg    <= '0;
      msgValid   <= 1'b0;
      msgTargets <= '0;
      msgDest    <= '0;
      selfValid  <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      msgValid  <= 1'b0;
      selfValid <= 1'b0;
      errPulse  <= ctl.err;
      if (wrHi) destReg <= wrData[DEST_LSB +: 8];
      if (ctl.load) begin
        loReg           <= wrData;
        loReg[STAT_BIT] <= 1'b0;
        msgValid        <= |remoteMask;
        msgTargets      <= remoteMask;
        msgDest         <= destReg;
        selfValid       <= selfHit;
      end else begin
        msgTargets <= '0;
      end
    end
  end

  always_comb begin
    loWord           = loReg;
    loWord[STAT_BIT] = busy;
  end
  assign hiWord = {destReg, 24'h0};
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrLo,
  input  logic               wrHi,
  input  logic [31:0]        wrData,
  input  logic [ID_W-1:0]    localId,
  input  logic [ID_W:0]      numProcs,
  input  logic               respValid,
  output logic [31:0]        loWord,
  output logic [31:0]        hiWord,
  output logic               msgValid,
  output logic [NUM_CPU-1:0] msgTargets,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgDelMode,
  output logic               msgDestMode,
  output logic               msgLevel,
  output logic               msgTrigger,
  output logic [7:0]         msgDest,
  output logic               selfValid,
  output logic               errPulse,
  output logic               busy
);
  ctlStrobe_t         ctl;
  logic [NUM_CPU-1:0] remoteMask;

  ipi_ctrl #(.NUM_CPU(NUM_CPU)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .respValid(respValid),
    .reqMode(wrData[MODE_LSB +: 3]), .reqShort(wrData[SH_LSB +: 2]),
    .remoteMask(remoteMask), .ctl(ctl), .busy(busy)
  );

  ipi_datapath #(.NUM_CPU(NUM_CPU)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrHi(wrHi), .wrData(wrData),
    .localId(localId), .numProcs(numProcs), .busy(busy),
    .remoteMask(remoteMask), .loWord(loWord), .hiWord(hiWord),
    .msgValid(msgValid), .msgTargets(msgTargets), .msgDest(msgDest),
    .selfValid(selfValid), .errPulse(errPulse)
  );

  assign msgVector   = loWord[VEC_LSB +: 8];
  assign msgDelMode  = loWord[MODE_LSB +: 3];
  assign msgDestMode = loWord[DMODE_BIT];
  assign msgLevel    = loWord[LEVEL_BIT];
  assign msgTrigger  = loWord[TRIG_BIT];
endmodule

// File: rtl/ipi_cmd_sender_chk.sv
module ipi_cmd_sender_chk #(
  parameter int NUM_CPU = 8,
  localparam int ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrLo,
  input logic               wrHi,
  input logic [ID_W:0]      numProcs,
  input logic               respValid,
  input logic [31:0]        loWord,
  input logic [31:0]        hiWord,
  input logic               msgValid,
  input logic [NUM_CPU-1:0] msgTargets,
  input logic               selfValid,
  input logic               errPulse,
  input logic               busy
);
  // R1
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && busy) |=> (!msgValid && !selfValid && loWord[11:0] == $past(loWord[11:0])));
  // R7
  busy_with_message_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> busy);
  // R7
  busy_clears_on_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(respValid));
  // R9
  err_sends_nothing_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!msgValid && !selfValid && !busy));
  // R10
  hi_low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> (hiWord[23:0] == 24'h0));
  // R11
  targets_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> ((NUM_CPU + ID_W + 1)'(msgTargets) >> numProcs) == '0);
  // R2
  status_mirrors_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWord[12] == busy);
endmodule

bind ipi_cmd_sender ipi_cmd_sender_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .numProcs(numProcs),
  .respValid(respValid), .loWord(loWord), .hiWord(hiWord),
  .msgValid(msgValid), .msgTargets(msgTargets), .selfValid(selfValid),
  .errPulse(errPulse), .busy(busy)
);

// File: tb/tb_ipi_cmd_sender.sv
module tb_ipi_cmd_sender;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrLo = 1'b0, wrHi = 1'b0, respValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0]  localId = '0;
  logic [3:0]  numProcs = 4'd8;
  logic [31:0] loWord, hiWord;
  logic        msgValid, msgDestMode, msgLevel, msgTrigger, selfValid, errPulse, busy;
  logic [N-1:0] msgTargets;
  logic [7:0]  msgVector, msgDest;
  logic [2:0]  msgDelMode;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ipi_cmd_sender #(.NUM_CPU(N)) dut (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .localId(localId), .numProcs(numProcs), .respValid(respValid),
    .loWord(loWord), .hiWord(hiWord), .msgValid(msgValid),
    .msgTargets(msgTargets), .msgVector(msgVector), .msgDelMode(msgDelMode),
    .msgDestMode(msgDestMode), .msgLevel(msgLevel), .msgTrigger(msgTrigger),
    .msgDest(msgDest), .selfValid(selfValid), .errPulse(errPulse), .busy(busy)
  );

  typedef struct packed {
    logic [7:0]  dest;
    logic [31:0] lo;
    logic [2:0]  lid;
    logic [3:0]  np;
    logic [7:0]  tgt;
    logic        self;
    logic        err;
  } vec_t;

  // lo: [7:0] vector, [10:8] mode, [11] logical, [14] level, [15] trigger, [19:18] shorthand
  localparam vec_t TBL [10] = '{
    '{8'hFF, 32'h0000_4040, 3'd2, 4'd8, 8'hFB, 1'b1, 1'b0},  // R3 broadcast
    '{8'h05, 32'h0000_8041, 3'd2, 4'd8, 8'h20, 1'b0, 1'b0},  // R4 single remote
    '{8'h02, 32'h0000_0242, 3'd2, 4'd8, 8'h00, 1'b1, 1'b0},  // R4 R8 self by dest
    '{8'h36, 32'h0000_C843, 3'd2, 4'd4, 8'h06, 1'b0, 1'b0},  // R5 R11 logical
    '{8'h00, 32'h0004_0044, 3'd3, 4'd8, 8'h00, 1'b1, 1'b0},  // R6 self only
    '{8'h00, 32'h0008_0045, 3'd0, 4'd3, 8'h06, 1'b1, 1'b0},  // R6 R11 all incl self
    '{8'h00, 32'h000C_0446, 3'd7, 4'd8, 8'h7F, 1'b0, 1'b0},  // R6 all but self
    '{8'h06, 32'h0000_0047, 3'd1, 4'd4, 8'h00, 1'b0, 1'b0},  // R11 dest out of range
    '{8'h03, 32'h0000_0148, 3'd1, 4'd8, 8'h00, 1'b0, 1'b1},  // R9 lowest priority
    '{8'h03, 32'h0004_0149, 3'd1, 4'd8, 8'h00, 1'b1, 1'b0}   // R9 low pri ok with shorthand
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeHi(input logic [7:0] d);
    wrHi = 1'b1; wrData = {d, 24'hABCDEF};
    @(negedge clk);
    wrHi = 1'b0; wrData = '0;
  endtask

  task automatic writeLo(input logic [31:0] d);
    wrLo = 1'b1; wrData = d;
    @(negedge clk);
    wrLo = 1'b0; wrData = '0;
  endtask

  task automatic drain(input int cnt);
    for (int k = 0; k < cnt; k++) begin
      chk(busy == 1'b1, "R7 busy before response", 32'(busy), 32'd1);
      respValid = 1'b1;
      @(negedge clk);
      respValid = 1'b0;
    end
    chk(busy == 1'b0, "R7 busy after last response", 32'(busy), 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] expLo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(loWord == 0 && hiWord == 0 && !busy && !msgValid && !selfValid && !errPulse,
        "R2 reset state", loWord, 32'h0);

    expLo = '0;
    for (int i = 0; i < 10; i++) begin
      localId = TBL[i].lid; numProcs = TBL[i].np;
      writeHi(TBL[i].dest);
      writeLo(TBL[i].lo);
      if (!TBL[i].err) expLo = TBL[i].lo;
      chk(msgTargets == (TBL[i].err ? 8'h00 : TBL[i].tgt), "R3 R4 R5 R6 R11 targets",
          32'(msgTargets), 32'(TBL[i].tgt));
      chk(msgValid == (!TBL[i].err && TBL[i].tgt != 0), "R2 msgValid", 32'(msgValid),
          32'(!TBL[i].err && TBL[i].tgt != 0));
      chk(selfValid == TBL[i].self, "R3 R4 R6 selfValid", 32'(selfValid), 32'(TBL[i].self));
      chk(errPulse == TBL[i].err, "R9 errPulse", 32'(errPulse), 32'(TBL[i].err));
      chk(busy == (!TBL[i].err && TBL[i].tgt != 0), "R7 R8 busy", 32'(busy),
          32'(!TBL[i].err && TBL[i].tgt != 0));
      chk({loWord[31:13], loWord[11:0]} == {expLo[31:13], expLo[11:0]}, "R2 R9 loWord",
          loWord, expLo);
      if (!TBL[i].err && (TBL[i].tgt != 0 || TBL[i].self)) begin
        chk({msgVector, msgDelMode, msgDestMode, msgLevel, msgTrigger, msgDest} ==
            {TBL[i].lo[7:0], TBL[i].lo[10:8], TBL[i].lo[11], TBL[i].lo[14], TBL[i].lo[15], TBL[i].dest},
            "R2 message fields", {msgVector, msgDest, 16'h0}, {TBL[i].lo[7:0], TBL[i].dest, 16'h0});
      end
      @(negedge clk);
      chk(!msgValid && !selfValid && !errPulse, "R2 strobes one cycle", 32'(msgValid), 32'd0);
      if (!TBL[i].err) drain($countones(TBL[i].tgt));
    end

    // R1: write while busy is dropped
    localId = 3'd0; numProcs = 4'd8;
    writeHi(8'hFF);
    writeLo(32'h0000_0050);
    chk(busy == 1'b1 && msgTargets == 8'hFE, "R1 setup", 32'(msgTargets), 32'hFE);
    writeLo(32'h000C_0099);
    chk(!msgValid && !selfValid, "R1 no message when busy", 32'(msgValid), 32'd0);
    chk(loWord == 32'h0000_1050, "R1 low word kept", loWord, 32'h0000_1050);
    drain(7);
    chk(loWord == 32'h0000_0050, "R7 status bit cleared", loWord, 32'h0000_0050);

    // R7: responses while idle do nothing
    respValid = 1'b1;
    repeat (3) @(negedge clk);
    respValid = 1'b0;
    chk(!busy && loWord[12] == 1'b0, "R7 idle responses ignored", 32'(busy), 32'd0);
    writeHi(8'h04);
    writeLo(32'h0000_0051);
    chk(busy && msgTargets == 8'h10, "R7 single target after idle resp", 32'(msgTargets), 32'h10);
    drain(1);

    // R10: high word masking
    wrHi = 1'b1; wrData = 32'hFFFF_FFFF;
    @(negedge clk);
    wrHi = 1'b0; wrData = '0;
    chk(hiWord == 32'hFF00_0000, "R10 high word mask", hiWord, 32'hFF00_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule